// File: doc/BRIEF.md
# Reorder Buffer Source Operand Resolver

This unit sits at the issue stage of an out-of-order core. For each source register of the instruction being issued, it decides where the operand comes from. It scans the in-flight entries of a circular reorder buffer for the youngest entry that writes that register. There are three outcomes:

- If that entry has already produced its result, the value is forwarded at once.
- If the entry is still executing, the unit returns the entry's index as a tag to wait on.
- If no in-flight entry writes the register, the value read from the architectural register file is passed through.

The unit is purely combinational. It sees the buffer only through its ports: the head and tail pointers plus the per-entry valid, destination, done and value fields. It has several source ports that work independently, so every operand of one instruction resolves in the same cycle. The pointers wrap modulo the buffer depth. The head names the oldest entry and the tail names the next free slot. Head equal to tail means the buffer is empty. A full buffer holds depth minus one entries.

Top module: `rob_operand_lookup`

## Requirements
- R1: An entry is a candidate only if its valid bit is set and its index lies in the live window, meaning its distance (index − head) mod N is smaller than (tail − head) mod N.
- R2: When several candidates write the requested register, the one with the largest distance from head (the youngest) decides the result.
- R3: If the deciding entry has its done bit set, ready_o is 1, value_o is that entry's value and wait_tag_o is 0.
- R4: If the deciding entry has its done bit clear, ready_o is 0, wait_tag_o is that entry's index and value_o is 0.
- R5: The distance ordering stays correct when the live window wraps past index N−1 back to index 0.
- R6: With head_i equal to tail_i, every port returns its register-file value with ready_o set, whatever the entry fields hold.
- R7: Source register 0 always yields ready_o = 1, value_o = 0 and wait_tag_o = 0. It is never matched against entries, and its register-file input is ignored.
- R8: Each source port resolves on its own. The register number on one port has no effect on the outputs of another port.
- R9: If no candidate writes a nonzero source register, ready_o is 1, value_o equals that port's rf_data_i and wait_tag_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_reg_i | input | NUM_SRC*REG_W | Source register number for each port |
| rf_data_i | input | NUM_SRC*DATA_W | Register-file read data for each port |
| head_i | input | IDX_W | Index of the oldest in-flight entry |
| tail_i | input | IDX_W | Index of the next free entry |
| ent_valid_i | input | N_ENTRIES | Per-entry occupied flag |
| ent_dest_i | input | N_ENTRIES*REG_W | Per-entry destination register |
| ent_done_i | input | N_ENTRIES | Per-entry result-available flag |
| ent_value_i | input | N_ENTRIES*DATA_W | Per-entry result value |
| ready_o | output | NUM_SRC | Operand available on this port |
| value_o | output | NUM_SRC*DATA_W | Resolved operand value |
| wait_tag_o | output | NUM_SRC*IDX_W | Producing entry to wait for when not ready |

## Verification
The hardest case to reach is a wrapped window that holds several writers of the same register. In that case the youngest writer sits at a lower index than an older one, so a plain index-order search gives the wrong answer. The directed table places head near the top of the buffer, with matching entries on both sides of the wrap point. Some of those entries are done and some are pending, so a wrong ordering shows up as a wrong value or a wrong tag. A random phase then draws destinations from a small register range to force many conflicts, draws pointers freely (including the full and empty positions), and compares both ports against a sequential walk from head to tail.

// File: rtl/rob_lookup_pkg.sv
package rob_lookup_pkg;
  localparam int unsigned DEF_N_ENTRIES = 8;
  localparam int unsigned DEF_REG_W     = 5;
  localparam int unsigned DEF_DATA_W    = 32;
  localparam int unsigned DEF_NUM_SRC   = 2;

  // forward distance on a ring of n slots
  function automatic int unsigned ring_dist(int unsigned from_idx,
                                            int unsigned to_idx,
                                            int unsigned n);
    return (to_idx + n - from_idx) % n;
  endfunction
endpackage

// File: rtl/rob_age_window.sv
module rob_age_window
  import rob_lookup_pkg::*;
#(
  parameter int unsigned N_ENTRIES = DEF_N_ENTRIES,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
  input  logic [IDX_W-1:0]                 head_i,
  input  logic [IDX_W-1:0]                 tail_i,
  input  logic [N_ENTRIES-1:0]             valid_i,
  output logic [N_ENTRIES-1:0]             live_o,
  output logic [N_ENTRIES-1:0][IDX_W-1:0]  age_o
);
  logic [IDX_W-1:0] occ;

  assign occ = IDX_W'(ring_dist(int'(head_i), int'(tail_i), N_ENTRIES));

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    assign age_o[e]  = IDX_W'(ring_dist(int'(head_i), e, N_ENTRIES));
    assign live_o[e] = valid_i[e] && (age_o[e] < occ);
  end

  // R6: empty ring exposes no live entry
  always_comb begin
    if (head_i == tail_i)
      a_r6_empty_no_live: assert (live_o == '0) else $error("live entry in empty ring");
  end
endmodule

// File: rtl/rob_dest_match.sv
module rob_dest_match
  import rob_lookup_pkg::*;
#(
  parameter int unsigned N_ENTRIES = DEF_N_ENTRIES,
  parameter int unsigned REG_W     = DEF_REG_W
) (
  input  logic [REG_W-1:0]                 src_i,
  input  logic [N_ENTRIES-1:0]             live_i,
  input  logic [N_ENTRIES-1:0][REG_W-1:0]  dest_i,
  output logic [N_ENTRIES-1:0]             hit_o
);
  logic src_nz;
  assign src_nz = (src_i != '0);

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    assign hit_o[e] = src_nz && live_i[e] && (dest_i[e] == src_i);
  end
endmodule

// File: rtl/rob_youngest_pick.sv
module rob_youngest_pick
  import rob_lookup_pkg::*;
#(
  parameter int unsigned N_ENTRIES = DEF_N_ENTRIES,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
  input  logic [N_ENTRIES-1:0]             hit_i,
  input  logic [N_ENTRIES-1:0][IDX_W-1:0]  age_i,
  output logic                             found_o,
  output logic [IDX_W-1:0]                 pick_o
);
  logic [IDX_W-1:0] best_age;

  always_comb begin
    found_o  = 1'b0;
    pick_o   = '0;
    best_age = '0;
    for (int e = 0; e < N_ENTRIES; e++) begin
      if (hit_i[e] && (!found_o || age_i[e] > best_age)) begin
        found_o  = 1'b1;
        pick_o   = IDX_W'(e);
        best_age = age_i[e];
      end
    end
  end

  always_comb begin
    a_r1_found_iff_hit: assert (found_o == (hit_i != '0)) else $error("found flag mismatch");
    if (found_o) begin
      a_r1_pick_is_hit: assert (hit_i[pick_o]) else $error("picked entry not a hit");
      for (int e = 0; e < N_ENTRIES; e++)
        if (hit_i[e])
          a_r2_youngest: assert (age_i[e] <= age_i[pick_o]) else $error("older entry picked");
    end
  end
endmodule

// File: rtl/rob_operand_lookup.sv
module rob_operand_lookup
  import rob_lookup_pkg::*;
#(
  parameter int unsigned N_ENTRIES = DEF_N_ENTRIES,
  parameter int unsigned REG_W     = DEF_REG_W,
  parameter int unsigned DATA_W    = DEF_DATA_W,
  parameter int unsigned NUM_SRC   = DEF_NUM_SRC,
  localparam int unsigned IDX_W = $clog2(N_ENTRIES)
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0]    src_reg_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0]   rf_data_i,
  input  logic [IDX_W-1:0]                 head_i,
  input  logic [IDX_W-1:0]                 tail_i,
  input  logic [N_ENTRIES-1:0]             ent_valid_i,
  input  logic [N_ENTRIES-1:0][REG_W-1:0]  ent_dest_i,
  input  logic [N_ENTRIES-1:0]             ent_done_i,
  input  logic [N_ENTRIES-1:0][DATA_W-1:0] ent_value_i,
  output logic [NUM_SRC-1:0]               ready_o,
  output logic [NUM_SRC-1:0][DATA_W-1:0]   value_o,
  output logic [NUM_SRC-1:0][IDX_W-1:0]    wait_tag_o
);
  logic [N_ENTRIES-1:0]            live;
  logic [N_ENTRIES-1:0][IDX_W-1:0] age;

  rob_age_window #(.N_ENTRIES(N_ENTRIES)) i_window (
    .head_i (head_i),
    .tail_i (tail_i),
    .valid_i(ent_valid_i),
    .live_o (live),
    .age_o  (age)
  );

  for (genvar p = 0; p < NUM_SRC; p++) begin : g_port
    logic [N_ENTRIES-1:0] hit;
    logic                 found;
    logic [IDX_W-1:0]     pick;
    logic                 src_zero;

    assign src_zero = (src_reg_i[p] == '0);

    rob_dest_match #(.N_ENTRIES(N_ENTRIES), .REG_W(REG_W)) i_match (
      .src_i (src_reg_i[p]),
      .live_i(live),
      .dest_i(ent_dest_i),
      .hit_o (hit)
    );

    rob_youngest_pick #(.N_ENTRIES(N_ENTRIES)) i_pick (
      .hit_i  (hit),
      .age_i  (age),
      .found_o(found),
      .pick_o (pick)
    );

    always_comb begin
      ready_o[p]    = 1'b1;
      value_o[p]    = '0;
      wait_tag_o[p] = '0;
      if (src_zero) begin
        value_o[p] = '0;
      end else if (!found) begin
        value_o[p] = rf_data_i[p];
      end else if (ent_done_i[pick]) begin
        value_o[p] = ent_value_i[pick];
      end else begin
        ready_o[p]    = 1'b0;
        wait_tag_o[p] = pick;
      end
    end

    always_comb begin
      if (src_zero)
        a_r7_zero_no_hit: assert (!found) else $error("register 0 matched");
      if (head_i == tail_i)
        a_r6_empty_no_hit: assert (!found) else $error("hit in empty ring");
      if (found)
        a_r1_pick_live: assert (live[pick]) else $error("picked entry outside window");
    end
  end
endmodule

// File: tb/test_rob_operand_lookup.sv
module test_rob_operand_lookup;
  localparam int N  = 8;
  localparam int RW = 5;
  localparam int DW = 32;
  localparam int NS = 2;
  localparam int IW = 3;

  typedef struct packed {
    logic [IW-1:0] head;
    logic [IW-1:0] tail;
    logic [RW-1:0] src;
    logic          rdy;
    logic [DW-1:0] val;
    logic [IW-1:0] tag;
  } vec_t;

  // fixed ring: dest = {3,5,3,0,7,5,3,9}, done = {1,0,0,1,1,1,1,0}, value = 100+i, rf = 0xF00D
  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 5'd3, 1'b1, 32'hF00D, 3'd0},  // R6 empty
    '{3'd0, 3'd3, 5'd3, 1'b0, 32'd0,    3'd2},  // R2 R4
    '{3'd0, 3'd2, 5'd3, 1'b1, 32'd100,  3'd0},  // R3
    '{3'd0, 3'd7, 5'd5, 1'b1, 32'd105,  3'd0},  // R2 R3
    '{3'd6, 3'd2, 5'd3, 1'b1, 32'd100,  3'd0},  // R5 wrap
    '{3'd6, 3'd3, 5'd3, 1'b0, 32'd0,    3'd2},  // R5 R4
    '{3'd2, 3'd1, 5'd9, 1'b0, 32'd0,    3'd7},  // R4
    '{3'd4, 3'd6, 5'd3, 1'b1, 32'hF00D, 3'd0},  // R9
    '{3'd0, 3'd7, 5'd0, 1'b1, 32'd0,    3'd0},  // R7
    '{3'd7, 3'd0, 5'd9, 1'b0, 32'd0,    3'd7},  // R1 single entry
    '{3'd5, 3'd4, 5'd5, 1'b0, 32'd0,    3'd1},  // R5 full
    '{3'd1, 3'd0, 5'd7, 1'b1, 32'd104,  3'd0}   // R3
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [NS-1:0][RW-1:0] src_reg;
  logic [NS-1:0][DW-1:0] rf_data;
  logic [IW-1:0]         head, tail;
  logic [N-1:0]          ent_valid, ent_done;
  logic [N-1:0][RW-1:0]  ent_dest;
  logic [N-1:0][DW-1:0]  ent_value;
  logic [NS-1:0]         ready;
  logic [NS-1:0][DW-1:0] value;
  logic [NS-1:0][IW-1:0] wait_tag;

  int total = 0;
  int bad   = 0;

  rob_operand_lookup i_rob_operand_lookup (
    .src_reg_i  (src_reg),
    .rf_data_i  (rf_data),
    .head_i     (head),
    .tail_i     (tail),
    .ent_valid_i(ent_valid),
    .ent_dest_i (ent_dest),
    .ent_done_i (ent_done),
    .ent_value_i(ent_value),
    .ready_o    (ready),
    .value_o    (value),
    .wait_tag_o (wait_tag)
  );

  task automatic check(input string req, input int p,
                       input logic er, input logic [DW-1:0] ev, input logic [IW-1:0] et);
    total++;
    if (ready[p] !== er || value[p] !== ev || wait_tag[p] !== et) begin
      bad++;
      $display("FAIL %s port%0d: got rdy=%0b val=%0h tag=%0d exp rdy=%0b val=%0h tag=%0d",
               req, p, ready[p], value[p], wait_tag[p], er, ev, et);
    end
  endtask

  task automatic load_fixed();
    logic [RW-1:0] d [N] = '{5'd3, 5'd5, 5'd3, 5'd0, 5'd7, 5'd5, 5'd3, 5'd9};
    logic [N-1:0]  dn = 8'b0111_1001;
    for (int i = 0; i < N; i++) begin
      ent_dest[i]  = d[i];
      ent_value[i] = DW'(100 + i);
    end
    ent_done  = dn;
    ent_valid = '1;
    rf_data   = '{32'hBEEF, 32'hF00D};
  endtask

  // sequential walk from head towards tail, last writer wins
  task automatic ref_lookup(input int p, output logic r, output logic [DW-1:0] v,
                            output logic [IW-1:0] t);
    int idx;
    int cnt;
    int hit;
    hit = -1;
    idx = int'(head);
    cnt = (int'(tail) - int'(head) + N) % N;
    for (int k = 0; k < cnt; k++) begin
      if (ent_valid[idx] && src_reg[p] != 0 && ent_dest[idx] == src_reg[p]) hit = idx;
      idx = (idx + 1) % N;
    end
    r = 1'b1; v = '0; t = '0;
    if (src_reg[p] == 0) v = '0;
    else if (hit < 0) v = rf_data[p];
    else if (ent_done[hit]) v = ent_value[hit];
    else begin r = 1'b0; t = IW'(hit); end
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic er;
    logic [DW-1:0] ev;
    logic [IW-1:0] et;

    // idle state: everything zero, empty ring
    src_reg = '0; rf_data = '0; head = '0; tail = '0;
    ent_valid = '0; ent_done = '0; ent_dest = '0; ent_value = '0;
    @(negedge clk);
    check("R7 idle", 0, 1'b1, '0, '0);
    check("R7 idle", 1, 1'b1, '0, '0);

    // directed table
    load_fixed();
    for (int v = 0; v < NV; v++) begin
      @(posedge clk);
      head = VECS[v].head; tail = VECS[v].tail;
      src_reg[0] = VECS[v].src; src_reg[1] = '0;
      @(negedge clk);
      check($sformatf("R1-table vec%0d", v), 0, VECS[v].rdy, VECS[v].val, VECS[v].tag);
    end

    // R6: empty ring ignores full contents on both ports
    @(posedge clk);
    head = 3'd5; tail = 3'd5; src_reg = '{5'd5, 5'd3};
    @(negedge clk);
    check("R6", 0, 1'b1, 32'hF00D, '0);
    check("R6", 1, 1'b1, 32'hBEEF, '0);

    // R1: cleared valid bit removes the youngest writer
    @(posedge clk);
    head = 3'd0; tail = 3'd3; src_reg = '{5'd0, 5'd3}; ent_valid[2] = 1'b0;
    @(negedge clk);
    check("R1 invalid entry", 0, 1'b1, 32'd100, '0);
    ent_valid[2] = 1'b1;

    // R8: two ports resolve independently
    @(posedge clk);
    src_reg = '{5'd5, 5'd3};
    @(negedge clk);
    check("R8 port0", 0, 1'b0, '0, 3'd2);
    check("R8 port1", 1, 1'b0, '0, 3'd1);
    @(posedge clk);
    src_reg[1] = 5'd7;
    @(negedge clk);
    check("R8 port0 unchanged", 0, 1'b0, '0, 3'd2);
    check("R9 port1", 1, 1'b1, 32'hBEEF, '0);

    // R7: register 0 ignores a live dest-0 entry and the rf input
    @(posedge clk);
    head = 3'd2; tail = 3'd5; src_reg = '{5'd0, 5'd0}; rf_data = '{32'h1234, 32'h5678};
    @(negedge clk);
    check("R7", 0, 1'b1, '0, '0);
    check("R7", 1, 1'b1, '0, '0);

    // random compare against the walk model (R2 R5)
    for (int it = 0; it < 3000; it++) begin
      @(posedge clk);
      for (int i = 0; i < N; i++) begin
        ent_dest[i]  = RW'($urandom_range(0, 4));
        ent_value[i] = $urandom;
      end
      ent_valid = N'($urandom);
      ent_done  = N'($urandom);
      head      = IW'($urandom);
      tail      = IW'($urandom);
      for (int p = 0; p < NS; p++) begin
        src_reg[p] = RW'($urandom_range(0, 4));
        rf_data[p] = $urandom;
      end
      @(negedge clk);
      for (int p = 0; p < NS; p++) begin
        ref_lookup(p, er, ev, et);
        check("R2 R5 random", p, er, ev, et);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule